// File: doc/BRIEF.md
# Boot-Source Selector with Blank-Flash Check

This block sits in a flash controller and decides where the processor boots. At power-on it looks at the first word of main flash. If that word is still in the erased state (all ones) and the straps ask for a main-flash boot, it latches a "flash blank" flag. While that flag is set, the boot-source output sends the processor to system memory instead of main flash. The flag is a latched decision. An ordinary system reset does not touch it, so a board that has just been programmed keeps booting from system memory until the flag is refreshed.

Software has two ways to refresh the flag. It can unlock the control and option areas with their key sequences and issue a reload command. The reload re-samples the first flash word, updates the flag and raises a one-cycle reset request. Software can also toggle the flag directly through the status register.

Four states run the sequencing. CS_EVAL samples the flash word and goes to CS_IDLE after power-on, or to CS_RSTREQ after a reload. CS_IDLE waits and goes to CS_LOAD on an accepted reload command. CS_LOAD waits LOAD_CYCLES cycles for the word to settle, then goes to CS_EVAL. A system reset sends it back to CS_IDLE. CS_RSTREQ raises the reset request and goes to CS_IDLE; a system reset also sends it to CS_IDLE.

Each key register has its own lock machine with four states. KS_FIRST waits for the first key: a match goes to KS_SECOND, anything else goes to KS_BLOCKED. KS_SECOND waits for the second key: a match goes to KS_OPEN, anything else goes to KS_BLOCKED. KS_OPEN is the unlocked state and ignores further key writes. KS_BLOCKED stays until power-on reset.

Top module: `boot_sel_ctrl`

## Requirements
- R1: On the first clock edge after power-on reset is released, the blank flag (status offset 0x10, bit 0) becomes 1 exactly when boot_main is 1 and flash_word0 is 0xFFFFFFFF; otherwise it becomes 0.
- R2: boot_system is 1 when boot_main is 0 or the blank flag is 1, and is 0 otherwise.
- R3: Writing 0x45670123 and then 0xCDEF89AB to offset 0x08 unlocks the control register. Control bit 31 reads 1 while it is locked and 0 once it is unlocked.
- R4: Writing 0x08192A3B and then 0x4C5D6E7F to offset 0x0C unlocks the option area. Control bit 30 reads 1 while it is locked and 0 once it is unlocked.
- R5: A wrong value written to a key register, or the second key written first, blocks that key register until power-on reset. A correct sequence written after that leaves the area locked.
- R6: While the control register is locked, writes to offset 0x14 are dropped. Its field in bits [15:0] reads back unchanged.
- R7: A write of 1 to control bit 27 starts a reload only when both areas are unlocked. Otherwise bit 27 reads 0, the flag is unchanged and no reset request occurs.
- R8: An accepted reload keeps bit 27 at 1 for exactly LOAD_CYCLES+2 cycles. During that time it re-evaluates the flag by the R1 rule, so a programmed word with boot_main at 1 clears the flag. It raises rst_req for exactly one cycle, and bit 27 then clears itself.
- R9: A write to offset 0x10 with bit 0 at 1 inverts the blank flag. A write with bit 0 at 0 leaves the flag as it was.
- R10: Holding sys_rst_n low clears control bits [15:0] and abandons a reload in progress: no rst_req is raised and the flag is not updated. The blank flag and both lock states are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| flash_word0 | input | 32 | First word of main flash |
| boot_main | input | 1 | Boot straps request main flash |
| boot_system | output | 1 | 1 = boot from system memory |
| rst_req | output | 1 | One-cycle reset request at the end of a reload |

## Verification
The hardest case to reach from the ports is a reload that is abandoned halfway. The bench must first pass both key machines, issue the launch, change flash_word0 so that a completed evaluation would flip the flag, and then pulse the system reset while CS_LOAD is still counting. The bench drives that sequence directly. It then confirms that no reset request appeared, that the flag kept its value and that the locks stayed open. Randomly chosen key pairs with a fixed seed, each after its own power-on, show that a blocked key machine cannot be reopened by a correct sequence.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
    localparam int unsigned DATA_W = 32;

    localparam logic [7:0] OFS_KEY    = 8'h08;
    localparam logic [7:0] OFS_OPTKEY = 8'h0C;
    localparam logic [7:0] OFS_STAT   = 8'h10;
    localparam logic [7:0] OFS_CTRL   = 8'h14;

    localparam logic [DATA_W-1:0] CTRL_KEY_A = 32'h4567_0123;
    localparam logic [DATA_W-1:0] CTRL_KEY_B = 32'hCDEF_89AB;
    localparam logic [DATA_W-1:0] OPT_KEY_A  = 32'h0819_2A3B;
    localparam logic [DATA_W-1:0] OPT_KEY_B  = 32'h4C5D_6E7F;
    localparam logic [DATA_W-1:0] ERASED     = 32'hFFFF_FFFF;

    localparam int unsigned BIT_LAUNCH   = 27;
    localparam int unsigned BIT_OPT_LOCK = 30;
    localparam int unsigned BIT_CTL_LOCK = 31;
    localparam int unsigned FIELD_W      = 16;

    typedef enum logic [1:0] {
        KS_FIRST,
        KS_SECOND,
        KS_OPEN,
        KS_BLOCKED
    } key_state_t;

    typedef enum logic [1:0] {
        CS_EVAL,
        CS_IDLE,
        CS_LOAD,
        CS_RSTREQ
    } chk_state_t;
endpackage

// File: rtl/boot_sel_key_seq.sv
module boot_sel_key_seq
    import boot_sel_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_A = 32'h0,
    parameter logic [DATA_W-1:0] KEY_B = 32'h1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);
    key_state_t state_q, state_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= KS_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                KS_FIRST:   state_d = (wdata == KEY_A) ? KS_SECOND : KS_BLOCKED;
                KS_SECOND:  state_d = (wdata == KEY_B) ? KS_OPEN : KS_BLOCKED;
                KS_OPEN:    state_d = KS_OPEN;
                KS_BLOCKED: state_d = KS_BLOCKED;
            endcase
        end
    end

    always_comb begin
        unlocked = (state_q == KS_OPEN);
    end

    // R5: a blocked machine never opens again before power-on reset
    a_r5_blocked_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == KS_BLOCKED) |=> !unlocked);
    // R3: opening needs the second key in the second state
    a_r3_open_from_second: assert property (@(posedge clk) disable iff (!por_n)
        $rose(unlocked) |-> $past(state_q == KS_SECOND && wr_en && wdata == KEY_B));
endmodule

// File: rtl/boot_sel_empty_check.sv
module boot_sel_empty_check
    import boot_sel_pkg::*;
#(
    parameter int unsigned LOAD_CYCLES = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic [DATA_W-1:0] word0,
    input  logic              boot_main,
    input  logic              launch_req,
    input  logic              sw_toggle,
    output logic              blank_flag,
    output logic              busy,
    output logic              rst_req
);
    localparam int unsigned CNT_W = (LOAD_CYCLES < 2) ? 1 : $clog2(LOAD_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOAD_CYCLES - 1);

    chk_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= CS_EVAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_EVAL:   state_d = busy ? CS_RSTREQ : CS_IDLE;
            CS_IDLE:   if (launch_req && sys_rst_n) state_d = CS_LOAD;
            CS_LOAD:   if (!sys_rst_n) state_d = CS_IDLE;
                       else if (cnt_q == '0) state_d = CS_EVAL;
            CS_RSTREQ: state_d = CS_IDLE;
        endcase
    end

    // busy marks a software reload; it is clear during the power-on evaluation
    logic reload_q;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            reload_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            if (state_q == CS_IDLE && state_d == CS_LOAD) begin
                reload_q <= 1'b1;
                cnt_q    <= CNT_LAST;
            end else if (state_d == CS_IDLE) begin
                reload_q <= 1'b0;
            end
            if (state_q == CS_LOAD && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 flag_q <= 1'b0;
        else if (state_q == CS_EVAL) flag_q <= boot_main && (word0 == ERASED);
        else if (sw_toggle)         flag_q <= ~flag_q;
    end

    always_comb begin
        busy       = reload_q;
        rst_req    = (state_q == CS_RSTREQ);
        blank_flag = flag_q;
    end

    // R8: the reset request lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);
    // R10: a system reset during loading ends the reload with no request
    a_r10_abort: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == CS_LOAD && !sys_rst_n) |=> (!busy && !rst_req));
    // R9: with no evaluation and no toggle, the flag holds
    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != CS_EVAL && !sw_toggle) |=> $stable(blank_flag));
endmodule

// File: rtl/boot_sel_ctrl.sv
module boot_sel_ctrl
    import boot_sel_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned LOAD_CYCLES = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       flash_word0,
    input  logic              boot_main,
    output logic              boot_system,
    output logic              rst_req
);
    localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(OFS_KEY);
    localparam logic [ADDR_W-1:0] A_OPTKEY = ADDR_W'(OFS_OPTKEY);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);

    logic               ctl_open, opt_open;
    logic               blank, busy;
    logic               wr_ctrl, launch_req, sw_toggle;
    logic [FIELD_W-1:0] field_q;

    boot_sel_key_seq #(.KEY_A(CTRL_KEY_A), .KEY_B(CTRL_KEY_B)) ctl_key_i (
        .clk(clk), .por_n(por_n),
        .wr_en(bus_wr && bus_addr == A_KEY),
        .wdata(bus_wdata), .unlocked(ctl_open)
    );

    boot_sel_key_seq #(.KEY_A(OPT_KEY_A), .KEY_B(OPT_KEY_B)) opt_key_i (
        .clk(clk), .por_n(por_n),
        .wr_en(bus_wr && bus_addr == A_OPTKEY),
        .wdata(bus_wdata), .unlocked(opt_open)
    );

    always_comb begin
        wr_ctrl    = bus_wr && (bus_addr == A_CTRL) && ctl_open;
        launch_req = wr_ctrl && opt_open && bus_wdata[BIT_LAUNCH];
        sw_toggle  = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];
    end

    boot_sel_empty_check #(.LOAD_CYCLES(LOAD_CYCLES)) chk_i (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .word0(flash_word0), .boot_main(boot_main),
        .launch_req(launch_req), .sw_toggle(sw_toggle),
        .blank_flag(blank), .busy(busy), .rst_req(rst_req)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)         field_q <= '0;
        else if (!sys_rst_n) field_q <= '0;
        else if (wr_ctrl)   field_q <= bus_wdata[FIELD_W-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STAT) begin
            bus_rdata[0] = blank;
        end else if (bus_addr == A_CTRL) begin
            bus_rdata[FIELD_W-1:0]  = field_q;
            bus_rdata[BIT_LAUNCH]   = busy;
            bus_rdata[BIT_OPT_LOCK] = !opt_open;
            bus_rdata[BIT_CTL_LOCK] = !ctl_open;
        end
        boot_system = !boot_main || blank;
    end

    // R7: a reload starts only with both areas open
    a_r7_launch_gated: assert property (@(posedge clk) disable iff (!por_n)
        $rose(busy) |-> $past(ctl_open && opt_open));
    // R6: the field holds while the control register is locked
    a_r6_locked_hold: assert property (@(posedge clk) disable iff (!por_n)
        (!ctl_open && sys_rst_n) |=> $stable(field_q));
    // R10: a system reset keeps both lock states
    a_r10_locks_kept: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && ctl_open && opt_open) |=> (ctl_open && opt_open));
    // R2: a blank flag forces system memory
    a_r2_blank_redirect: assert property (@(posedge clk) disable iff (!por_n)
        blank |-> boot_system);
endmodule

// File: tb/boot_sel_ctrl_tb_top.sv
`timescale 1ns/1ps
module boot_sel_ctrl_tb_top;
    localparam int unsigned LC = 4;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, sys_rst_n = 1'b1, bus_wr = 1'b0, boot_main = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, flash_word0 = '1, bus_rdata;
    logic        boot_system, rst_req;

    int n_chk = 0, n_bad = 0, n_req = 0;

    always #2 clk = ~clk;

    boot_sel_ctrl #(.ADDR_W(8), .LOAD_CYCLES(LC)) dut_i (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flash_word0(flash_word0), .boot_main(boot_main),
        .boot_system(boot_system), .rst_req(rst_req)
    );

    always @(negedge clk) if (rst_req) n_req++;

    function automatic logic exp_blank(input logic [31:0] w, input logic bm);
        return bm && (w == 32'hFFFF_FFFF);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic power_on(input logic [31:0] w, input logic bm);
        @(negedge clk);
        por_n = 1'b0; flash_word0 = w; boot_main = bm;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock_all();
        wr(8'h08, 32'h4567_0123); wr(8'h08, 32'hCDEF_89AB);
        wr(8'h0C, 32'h0819_2A3B); wr(8'h0C, 32'h4C5D_6E7F);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d, w;
        logic        bm, ok1, ok2, f;
        int          busy_n, req0;
        void'($urandom(32'd1234));

        // R1 / R2 / R3 / R4: reset state of an erased part
        power_on(32'hFFFF_FFFF, 1'b1);
        rd(8'h10, d); check("R1 erased flag", d, 32'h1);
        check("R2 erased boot", {31'b0, boot_system}, 32'h1);
        rd(8'h14, d); check("R3 R4 locked at reset", d, 32'hC000_0000);

        // R1 / R2 / R5: random power-on patterns and key pairs
        for (int i = 0; i < 16; i++) begin
            w  = ($urandom % 2) ? 32'hFFFF_FFFF : $urandom;
            bm = $urandom % 2;
            power_on(w, bm);
            rd(8'h10, d); check("R1 random eval", d, {31'b0, exp_blank(w, bm)});
            check("R2 random boot", {31'b0, boot_system}, {31'b0, !bm || exp_blank(w, bm)});
            ok1 = ($urandom % 3) != 0;
            ok2 = ($urandom % 3) != 0;
            if (i % 4 == 3) begin
                wr(8'h08, 32'hCDEF_89AB); ok1 = 1'b0; // second key first
            end else begin
                wr(8'h08, ok1 ? 32'h4567_0123 : 32'h4567_0123 ^ (32'h1 << (i % 32)));
            end
            wr(8'h08, ok2 ? 32'hCDEF_89AB : 32'h0000_0000);
            rd(8'h14, d); check("R3 R5 key pair", d[31], !(ok1 && ok2));
            wr(8'h08, 32'h4567_0123); wr(8'h08, 32'hCDEF_89AB);
            rd(8'h14, d); check("R5 retry after pair", d[31], !(ok1 && ok2));
        end

        // R4 / R5: option key order and a wrong option key
        power_on(32'h1234_5678, 1'b1);
        wr(8'h0C, 32'h4C5D_6E7F); wr(8'h0C, 32'h0819_2A3B); wr(8'h0C, 32'h4C5D_6E7F);
        rd(8'h14, d); check("R5 option out of order", d[30], 1'b1);
        power_on(32'h1234_5678, 1'b1);
        wr(8'h0C, 32'h0819_2A3B); wr(8'h0C, 32'h4C5D_6E7F);
        rd(8'h14, d); check("R4 option open", d[31:30], 2'b10);

        // R6: control writes dropped while locked
        wr(8'h14, 32'h0800_BEEF);
        rd(8'h14, d); check("R6 locked write", d, 32'h8000_0000);

        // R7: launch with only the control area open
        power_on(32'hFFFF_FFFF, 1'b1);
        wr(8'h08, 32'h4567_0123); wr(8'h08, 32'hCDEF_89AB);
        req0 = n_req;
        flash_word0 = 32'h0000_0001;
        wr(8'h14, 32'h0800_00A5);
        rd(8'h14, d); check("R7 gated launch bit", d, 32'h4000_00A5);
        repeat (LC + 4) @(negedge clk);
        rd(8'h10, d); check("R7 flag untouched", d, 32'h1);
        check("R7 no request", n_req - req0, 0);

        // R8: full reload clears the flag
        wr(8'h0C, 32'h0819_2A3B); wr(8'h0C, 32'h4C5D_6E7F);
        req0 = n_req;
        wr(8'h14, 32'h0800_0000);
        busy_n = 0;
        rd(8'h14, d);
        while (d[27] && busy_n < 100) begin
            busy_n++;
            @(negedge clk);
            rd(8'h14, d);
        end
        check("R8 busy length", busy_n, LC + 2);
        check("R8 one request", n_req - req0, 1);
        rd(8'h10, d); check("R8 flag cleared", d, 32'h0);
        check("R2 programmed boot", {31'b0, boot_system}, 32'h0);

        // R9: toggle by software
        wr(8'h10, 32'h0000_0000);
        rd(8'h10, d); check("R9 zero no effect", d, 32'h0);
        wr(8'h10, 32'h0000_0001);
        rd(8'h10, d); check("R9 toggle set", d, 32'h1);
        check("R2 toggled boot", {31'b0, boot_system}, 32'h1);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d); check("R9 toggle clear", d, 32'h0);

        // R10: system reset in the middle of a reload
        wr(8'h14, 32'h0000_1234);
        flash_word0 = 32'hFFFF_FFFF;
        req0 = n_req;
        wr(8'h14, 32'h0800_1234);
        sys_rst_n = 1'b0;
        @(negedge clk);
        sys_rst_n = 1'b1;
        repeat (LC + 4) @(negedge clk);
        check("R10 no request", n_req - req0, 0);
        rd(8'h10, d); check("R10 flag kept", d, 32'h0);
        rd(8'h14, d); check("R10 field cleared locks kept", d, 32'h0);

        // R1: plain system reset does not re-evaluate
        sys_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        sys_rst_n = 1'b1;
        @(negedge clk);
        rd(8'h10, d); f = d[0];
        check("R1 warm reset keeps flag", {31'b0, f}, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule